// File: doc/BRIEF.md
# Cascadable Serial Segment Driver Core

This block takes display data as a serial bit stream and turns it into a parallel set of segment drive signals for a direct-drive liquid crystal panel. Data enters through a shift chain clocked by a serial clock. A chip select, active low, gates the chain. A level-sensitive holding latch copies the chain to the display while the load input is high. Each segment output is the backplane waveform when its segment is off, and the inverse of the backplane when its segment is on. All outputs are logic level; any level translation happens outside the block.

The last stage of the chain is registered onto a serial output on the opposite clock edge, so devices can be daisy-chained and all share one clock. Two static test inputs can replace the latched data with all-off, all-on or alternating patterns. A force-off input, driven by an external backplane frequency monitor, blanks every segment whatever the test inputs and the latch hold.

Top module: `seg_drive_core`

## Requirements
- R1: While rst_ni is low the shift chain, holding latch and dout_o are all zero, so with test_mode_i = 00 and force_off_i low every seg_o bit equals bp_i.
- R2: A falling edge of clk_i with cs_ni high leaves the shift chain unchanged.
- R3: On each falling edge of clk_i with cs_ni low, din_i enters stage 1 and every stage moves one place toward stage 85. Stage k is segment k, and segment k is seg_o[k-1]. The first bit shifted in reaches segment 85 after 85 shifts.
- R4: dout_o takes the value of stage 85 on the rising edge of clk_i and holds it until the next rising edge. A falling-edge shift therefore does not change dout_o.
- R5: While load_i is high the latch follows the shift chain. While load_i is low the latch keeps the value it held when load_i fell.
- R6: With test_mode_i = 00 and force_off_i low, seg_o[k] = bp_i XOR latch bit k: a latched 1 gives the inverse of the backplane (segment on) and a latched 0 gives a copy of it (segment off).
- R7: With force_off_i low, test_mode_i = 01 makes every seg_o bit equal bp_i, and test_mode_i = 10 makes every seg_o bit equal ~bp_i. The latch contents play no part.
- R8: With force_off_i low and test_mode_i = 11, odd-numbered segments (seg_o[0], seg_o[2], ...) equal ~bp_i and even-numbered segments equal bp_i.
- R9: With force_off_i high every seg_o bit equals bp_i, in any test mode and for any latch contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial clock; chain shifts on falling edge, dout_o updates on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; enables shifting |
| din_i | input | 1 | Serial data input |
| load_i | input | 1 | Latch enable; latch transparent while high |
| test_mode_i | input | 2 | Display override: 00 normal, 01 all off, 10 all on, 11 alternating |
| force_off_i | input | 1 | Backplane monitor fault; forces all segments off |
| bp_i | input | 1 | Backplane waveform |
| dout_o | output | 1 | Cascade serial output from stage 85 |
| seg_o | output | 85 | Segment drive signals, seg_o[k-1] is segment k |

## Verification
The clocked checks take a sample of cs_ni, din_i and load_i at the rising edge and treat it as valid for the falling edge that follows. They therefore assume that these inputs change only in the half period just before a rising edge and stay stable through the falling edge. The bench drives every input 5 ns before a rising edge. It looks at the outputs 2 ns after the falling edge, so no change falls on a shift edge. The random stimulus is constrained in the same way, and so are the directed cases: the 85-shift fill, shifting with select high, and latch hold while loading is low.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
  typedef enum logic [1:0] {
    TM_NORMAL    = 2'b00,
    TM_ALL_OFF   = 2'b01,
    TM_ALL_ON    = 2'b10,
    TM_ALTERNATE = 2'b11
  } test_mode_e;

  // 1 marks an "on" segment in the alternating pattern (odd segment numbers)
  function automatic logic alt_on(input int unsigned idx);
    return (idx % 2) == 0;
  endfunction
endpackage

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
  parameter int unsigned N_SEG = 85
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             din_i,
  output logic [N_SEG-1:0] stages_o,
  output logic             dout_o
);
  logic [N_SEG-1:0] chain_q;
  logic             dout_q;

  // falling-edge capture; stage 1 is bit 0
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else if (!cs_ni) begin
      chain_q <= {chain_q[N_SEG-2:0], din_i};
    end
  end

  // rising-edge launch so a downstream falling-edge sampler sees settled data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 1'b0;
    end else begin
      dout_q <= chain_q[N_SEG-1];
    end
  end

  assign stages_o = chain_q;
  assign dout_o   = dout_q;
endmodule

// File: rtl/seg_hold_latch.sv
module seg_hold_latch #(
  parameter int unsigned N_SEG = 85
) (
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N_SEG-1:0] d_i,
  output logic [N_SEG-1:0] q_o
);
  logic [N_SEG-1:0] hold_q;

  always_latch begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (load_i) begin
      hold_q <= d_i;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/seg_pattern_mux.sv
module seg_pattern_mux
  import seg_drv_pkg::*;
#(
  parameter int unsigned N_SEG = 85
) (
  input  logic [N_SEG-1:0] latch_i,
  input  logic [1:0]       mode_i,
  input  logic             force_off_i,
  input  logic             bp_i,
  output logic [N_SEG-1:0] seg_o
);
  test_mode_e mode;
  assign mode = test_mode_e'(mode_i);

  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    localparam logic ALT_BIT = alt_on(k);
    logic on_bit;

    always_comb begin
      unique case (mode)
        TM_NORMAL:    on_bit = latch_i[k];
        TM_ALL_OFF:   on_bit = 1'b0;
        TM_ALL_ON:    on_bit = 1'b1;
        TM_ALTERNATE: on_bit = ALT_BIT;
        default:      on_bit = 1'b0;
      endcase
      if (force_off_i) on_bit = 1'b0;
    end

    // on = opposite phase of backplane
    assign seg_o[k] = bp_i ^ on_bit;
  end
endmodule

// File: rtl/seg_drive_core.sv
module seg_drive_core #(
  parameter int unsigned N_SEG = 85
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             din_i,
  input  logic             load_i,
  input  logic [1:0]       test_mode_i,
  input  logic             force_off_i,
  input  logic             bp_i,
  output logic             dout_o,
  output logic [N_SEG-1:0] seg_o
);
  logic [N_SEG-1:0] stages;
  logic [N_SEG-1:0] latch_q;

  seg_shift_chain #(.N_SEG(N_SEG)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .din_i    (din_i),
    .stages_o (stages),
    .dout_o   (dout_o)
  );

  seg_hold_latch #(.N_SEG(N_SEG)) u_latch (
    .rst_ni (rst_ni),
    .load_i (load_i),
    .d_i    (stages),
    .q_o    (latch_q)
  );

  seg_pattern_mux #(.N_SEG(N_SEG)) u_mux (
    .latch_i     (latch_q),
    .mode_i      (test_mode_i),
    .force_off_i (force_off_i),
    .bp_i        (bp_i),
    .seg_o       (seg_o)
  );
endmodule

// File: rtl/seg_drive_checker.sv
module seg_drive_checker #(
  parameter int unsigned N_SEG = 85
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             din_i,
  input logic             load_i,
  input logic [1:0]       test_mode_i,
  input logic             force_off_i,
  input logic             bp_i,
  input logic             dout_o,
  input logic [N_SEG-1:0] seg_o,
  input logic [N_SEG-1:0] stages_i,
  input logic [N_SEG-1:0] latch_i
);
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(stages_i)); // R2

  AST_SHIFT_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |=> stages_i == {$past(stages_i[N_SEG-2:0]), $past(din_i)}); // R3

  AST_DOUT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> dout_o == $past(stages_i[N_SEG-1])); // R4

  AST_LATCH_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> latch_i == stages_i); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $past(!load_i)) |-> $stable(latch_i)); // R5

  AST_NORMAL_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_off_i && test_mode_i == 2'b00) |-> seg_o == (latch_i ^ {N_SEG{bp_i}})); // R6

  AST_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_off_i && test_mode_i == 2'b01) |-> seg_o == {N_SEG{bp_i}}); // R7

  AST_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_off_i && test_mode_i == 2'b10) |-> seg_o == ~{N_SEG{bp_i}}); // R7

  AST_ALT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_off_i && test_mode_i == 2'b11) |-> (seg_o[0] != bp_i && seg_o[1] == bp_i)); // R8

  AST_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |-> seg_o == {N_SEG{bp_i}}); // R9

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (stages_i == '0 && latch_i == '0 && dout_o == 1'b0); // R1
    end
  end
endmodule

bind seg_drive_core seg_drive_checker #(.N_SEG(N_SEG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .din_i       (din_i),
  .load_i      (load_i),
  .test_mode_i (test_mode_i),
  .force_off_i (force_off_i),
  .bp_i        (bp_i),
  .dout_o      (dout_o),
  .seg_o       (seg_o),
  .stages_i    (stages),
  .latch_i     (latch_q)
);

// File: tb/seg_drive_core_test.sv
module seg_drive_core_test;
  localparam int unsigned N = 85;
  localparam int unsigned WD_CYCLES = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         din = 1'b0;
  logic         load = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         force_off = 1'b0;
  logic         bp = 1'b0;
  logic         dout;
  logic [N-1:0] seg;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  logic [N-1:0] m_sr  = '0;
  logic [N-1:0] m_lat = '0;
  logic         m_dout = 1'b0;

  always #10ns clk = ~clk;

  seg_drive_core #(.N_SEG(N)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cs_ni       (cs_n),
    .din_i       (din),
    .load_i      (load),
    .test_mode_i (mode),
    .force_off_i (force_off),
    .bp_i        (bp),
    .dout_o      (dout),
    .seg_o       (seg)
  );

  function automatic logic [N-1:0] exp_seg(input logic [N-1:0] lat, input logic [1:0] md,
                                           input logic fo, input logic b);
    logic [N-1:0] on_v;
    case (md)
      2'b00: on_v = lat;
      2'b01: on_v = '0;
      2'b10: on_v = '1;
      default: for (int k = 0; k < N; k++) on_v[k] = (k % 2 == 0);
    endcase
    if (fo) on_v = '0;
    return on_v ^ {N{b}};
  endfunction

  function automatic string seg_tag(input logic [1:0] md, input logic fo);
    if (fo) return "R9";
    case (md)
      2'b00: return "R6";
      2'b11: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check_seg(input string tag);
    logic [N-1:0] e;
    e = exp_seg(m_lat, mode, force_off, bp);
    n_tests++;
    if (seg !== e) begin
      n_fail++;
      $display("FAIL %s seg actual=%h expected=%h", tag, seg, e);
    end
  endtask

  task automatic check_dout(input string tag);
    n_tests++;
    if (dout !== m_dout) begin
      n_fail++;
      $display("FAIL %s dout actual=%b expected=%b", tag, dout, m_dout);
    end
  endtask

  // starts 2 ns after a falling edge, ends 2 ns after the next one
  task automatic cyc(input logic c, input logic d, input logic ld, input logic [1:0] md,
                     input logic fo, input logic b, input string tag);
    #3ns;
    cs_n = c; din = d; load = ld; mode = md; force_off = fo; bp = b;
    @(posedge clk);
    m_dout = m_sr[N-1];
    #3ns;
    n_tests++;
    if (dout !== m_dout) begin
      n_fail++;
      $display("FAIL R4 dout after rise actual=%b expected=%b", dout, m_dout);
    end
    @(negedge clk);
    if (!c) m_sr = {m_sr[N-2:0], d};
    #2ns;
    if (ld) m_lat = m_sr;
    check_seg(tag == "" ? seg_tag(md, fo) : tag);
    check_dout("R4");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    bp = 1'b1;
    #35ns;
    n_tests++;
    if (seg !== {N{1'b1}} || dout !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset seg=%h dout=%b expected seg=all ones dout=0", seg, dout);
    end
    @(negedge clk);
    #5ns;
    rst_n = 1'b1;
    @(negedge clk);
    #2ns;

    // R3: single 1 travels to segment 85 after 85 shifts
    cyc(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R3");
    for (int i = 1; i < N; i++) cyc(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R3");
    cyc(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, "R3");
    n_tests++;
    if (seg !== ({{(N-1){1'b0}}, 1'b1} << (N-1))) begin
      n_fail++;
      $display("FAIL R3 seg actual=%h expected=bit84 only", seg);
    end
    // R4: that bit on dout after the following rise
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R4");
    n_tests++;
    if (dout !== 1'b1) begin
      n_fail++;
      $display("FAIL R4 dout actual=%b expected=1", dout);
    end

    // R2: select high, data ignored
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R2");
    cyc(1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, "R2");

    // R5: shift with load low, display must hold
    for (int i = 0; i < 30; i++) cyc(1'b0, i[0], 1'b0, 2'b00, 1'b0, 1'b0, "R5");
    cyc(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, "R5");

    // R7, R8, R9 directed with both backplane phases
    for (int m = 0; m < 4; m++) begin
      cyc(1'b1, 1'b0, 1'b0, 2'(m), 1'b0, 1'b0, "");
      cyc(1'b1, 1'b0, 1'b0, 2'(m), 1'b0, 1'b1, "");
      cyc(1'b1, 1'b0, 1'b0, 2'(m), 1'b1, 1'b1, "R9");
    end

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic c, d, ld, fo, b;
      logic [1:0] md;
      c  = ($urandom % 10) < 3;
      d  = $urandom % 2;
      ld = ($urandom % 4) == 0;
      md = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'b00;
      fo = ($urandom % 10) == 0;
      b  = $urandom % 2;
      cyc(c, d, ld, md, fo, b, "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule